// File: doc/BRIEF.md
# Early Packet Threshold Monitor

This block follows how many bytes of the current packet have been moved into packet memory, for the transmit and the receive direction separately. Each direction has a control word with an enable bit and a 5-bit threshold in units of 64 bytes. When a packet's byte count rises strictly above the threshold times 64, the transmit side gives a one-cycle early-start pulse, so that the network side can begin sending before the whole frame is in memory. The receive side instead sets a sticky early-receive status bit, which drives an interrupt when the interrupt enable is set.

The packet movers give a start marker, a per-cycle count of bytes written, and an end marker for each direction. A small register port sets the two control words and reaches the event register. The event register holds the receive status, the interrupt enable and two sticky configuration-error flags. An enabled direction with a zero threshold never triggers. Instead it raises its configuration-error flag.

Top module: `early_thresh_mon`

## Requirements
- R1: After reset, tx_early_go, rx_early_stat and rx_irq are 0, and registers at addresses 0, 1 and 2 read 0.
- R2: Address 0 is the transmit control word and address 1 is the receive control word. In each, bit 7 is the enable and bits 4:0 are the threshold. All other bits read 0 and ignore writes, so writing 16'hFFFF reads back 16'h009F. Address 2 is the event register: bit 0 is the receive status, bit 1 is the interrupt enable, bit 2 is the transmit configuration error and bit 3 is the receive configuration error. Its other bits read 0. Address 3 reads 0. reg_rdata is combinational from reg_addr and the current register state, and a write takes effect at the clock edge that samples reg_we.
- R3: The trigger fires in the cycle where the packet's running byte count, including that cycle's bytes, becomes strictly greater than threshold×64. A count equal to threshold×64 does not fire. tx_early_go is high for exactly the one cycle after that byte strobe.
- R4: A direction fires at most once between two start markers. A start marker clears the count and re-arms the trigger, and the bytes given in the start cycle belong to the new packet.
- R5: Byte counts given after an end marker and before the next start marker are ignored. The bytes given in the end cycle still count.
- R6: With the enable bit clear, a direction never fires.
- R7: A receive trigger sets the receive status in the next cycle. Writing 1 to event bit 0 clears it, and a trigger in the same cycle as that clear leaves the status set.
- R8: rx_irq equals the receive status ANDed with the interrupt enable (event bit 1), and it follows a change of the enable in the cycle after the write.
- R9: When a direction is enabled with a zero threshold, it never fires. Its configuration-error flag (event bit 2 for transmit, bit 3 for receive) is set at each clock edge where that setting holds. The flag stays set until a 1 is written to it while the setting is no longer invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| tx_pkt_start | input | 1 | Transmit packet start marker |
| tx_bytes | input | 8 | Transmit bytes written this cycle |
| tx_pkt_end | input | 1 | Transmit packet end marker |
| rx_pkt_start | input | 1 | Receive packet start marker |
| rx_bytes | input | 8 | Receive bytes written this cycle |
| rx_pkt_end | input | 1 | Receive packet end marker |
| tx_early_go | output | 1 | One-cycle early transmit start pulse |
| rx_early_stat | output | 1 | Receive early status |
| rx_irq | output | 1 | Receive early interrupt |

## Verification
The trigger is driven with counts that stop exactly at the level and then step one byte over it, which separates a strictly-greater compare from a greater-or-equal one. Bursts after a trigger and back-to-back start markers with large counts show whether the trigger fires once per packet and re-arms only at a start marker. Bytes sent while no packet is open, followed by a fresh packet that stops at the level, reveal a counter that keeps counting between packets. A status clear that coincides with a new trigger, an enabled zero threshold, and a disabled direction cover the priority, error and enable paths. A behavioural model compares every output on every cycle.

// File: rtl/ethm_pkg.sv
package ethm_pkg;
  localparam int CTRL_W    = 16;
  localparam int THR_W     = 5;
  localparam int UNIT_LOG2 = 6;
  localparam int EN_BIT    = 7;
  localparam int LVL_W     = THR_W + UNIT_LOG2;
  localparam int NUM_DIR   = 2;

  localparam logic [1:0] ADDR_TXC = 2'd0;
  localparam logic [1:0] ADDR_RXC = 2'd1;
  localparam logic [1:0] ADDR_EVT = 2'd2;

  localparam int EV_STAT  = 0;
  localparam int EV_IE    = 1;
  localparam int EV_ERR0  = 2;

  // trigger level in bytes for a threshold in 64-byte units
  function automatic logic [LVL_W-1:0] trig_level(input logic [THR_W-1:0] thr);
    return {thr, {UNIT_LOG2{1'b0}}};
  endfunction

  // control word as seen on the register port
  function automatic logic [CTRL_W-1:0] pack_ctl(input logic en, input logic [THR_W-1:0] thr);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[EN_BIT] = en;
    w[THR_W-1:0] = thr;
    return w;
  endfunction
endpackage

// File: rtl/ethm_dir_tracker.sv
module ethm_dir_tracker
  import ethm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BYTES_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [THR_W-1:0]   thr,
  input  logic               pkt_start,
  input  logic [BYTES_W-1:0] bytes,
  input  logic               pkt_end,
  output logic               fire_evt,
  output logic               early_go,
  output logic               cfg_bad
);
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_next, level;
  logic             active_q, fired_q, tracking, armed;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [BYTES_W-1:0] b);
    logic [CNT_W:0] s;
    s = (CNT_W+1)'(a) + (CNT_W+1)'(b);
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  assign level    = CNT_W'(trig_level(thr));
  assign tracking = pkt_start | active_q;
  assign cnt_base = pkt_start ? '0 : cnt_q;
  assign cnt_next = sat_add(cnt_base, bytes);
  assign cfg_bad  = en & (thr == '0);
  assign armed    = en & ~cfg_bad & ~(fired_q & ~pkt_start);
  assign fire_evt = tracking & armed & (cnt_next > level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      fired_q  <= 1'b0;
      early_go <= 1'b0;
    end else begin
      if (tracking) cnt_q <= cnt_next;
      active_q <= tracking & ~pkt_end;
      fired_q  <= pkt_start ? fire_evt : (fired_q | fire_evt);
      early_go <= fire_evt;
    end
  end

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    early_go && !pkt_start |=> !early_go);
  p_above_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    early_go |-> cnt_q > $past(level));
  p_idle_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_start && !active_q |=> !early_go);
endmodule

// File: rtl/ethm_regs.sv
module ethm_regs
  import ethm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [1:0]           reg_addr,
  input  logic [CTRL_W-1:0]    reg_wdata,
  output logic [CTRL_W-1:0]    reg_rdata,
  output logic [NUM_DIR-1:0]   dir_en,
  output logic [THR_W-1:0]     dir_thr [NUM_DIR],
  input  logic                 rx_fire,
  input  logic [NUM_DIR-1:0]   cfg_bad,
  output logic                 rx_stat,
  output logic                 rx_ie
);
  logic [NUM_DIR-1:0] cerr_q;
  logic               wr_evt, clr_stat;
  logic [CTRL_W-1:0]  evt_word;

  assign wr_evt   = reg_we && (reg_addr == ADDR_EVT);
  assign clr_stat = wr_evt && reg_wdata[EV_STAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_en  <= '0;
      rx_stat <= 1'b0;
      rx_ie   <= 1'b0;
      cerr_q  <= '0;
      for (int d = 0; d < NUM_DIR; d++) dir_thr[d] <= '0;
    end else begin
      if (reg_we && (reg_addr == ADDR_TXC || reg_addr == ADDR_RXC)) begin
        dir_en[reg_addr[0]]  <= reg_wdata[EN_BIT];
        dir_thr[reg_addr[0]] <= reg_wdata[THR_W-1:0];
      end
      rx_stat <= rx_fire | (rx_stat & ~clr_stat);
      if (wr_evt) rx_ie <= reg_wdata[EV_IE];
      for (int d = 0; d < NUM_DIR; d++)
        cerr_q[d] <= cfg_bad[d] | (cerr_q[d] & ~(wr_evt & reg_wdata[EV_ERR0+d]));
    end
  end

  always_comb begin
    evt_word = '0;
    evt_word[EV_STAT] = rx_stat;
    evt_word[EV_IE]   = rx_ie;
    for (int d = 0; d < NUM_DIR; d++) evt_word[EV_ERR0+d] = cerr_q[d];
  end

  always_comb begin
    case (reg_addr)
      ADDR_TXC: reg_rdata = pack_ctl(dir_en[0], dir_thr[0]);
      ADDR_RXC: reg_rdata = pack_ctl(dir_en[1], dir_thr[1]);
      ADDR_EVT: reg_rdata = evt_word;
      default:  reg_rdata = '0;
    endcase
  end

  p_status_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire |=> rx_stat);
  p_cfg_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cerr_q[0] && !(wr_evt && reg_wdata[EV_ERR0]) |=> cerr_q[0]);
endmodule

// File: rtl/early_thresh_mon.sv
module early_thresh_mon
  import ethm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BYTES_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic               tx_pkt_start,
  input  logic [BYTES_W-1:0] tx_bytes,
  input  logic               tx_pkt_end,
  input  logic               rx_pkt_start,
  input  logic [BYTES_W-1:0] rx_bytes,
  input  logic               rx_pkt_end,
  output logic               tx_early_go,
  output logic               rx_early_stat,
  output logic               rx_irq
);
  logic [NUM_DIR-1:0] dir_en, fire_evt, early_go, cfg_bad, pkt_start, pkt_end;
  logic [THR_W-1:0]   dir_thr [NUM_DIR];
  logic [BYTES_W-1:0] dir_bytes [NUM_DIR];
  logic               rx_ie;

  assign pkt_start    = {rx_pkt_start, tx_pkt_start};
  assign pkt_end      = {rx_pkt_end, tx_pkt_end};
  assign dir_bytes[0] = tx_bytes;
  assign dir_bytes[1] = rx_bytes;

  ethm_regs u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .dir_en, .dir_thr, .rx_fire(fire_evt[1]), .cfg_bad,
    .rx_stat(rx_early_stat), .rx_ie
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    ethm_dir_tracker #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_trk (
      .clk, .rst_n, .en(dir_en[d]), .thr(dir_thr[d]),
      .pkt_start(pkt_start[d]), .bytes(dir_bytes[d]), .pkt_end(pkt_end[d]),
      .fire_evt(fire_evt[d]), .early_go(early_go[d]), .cfg_bad(cfg_bad[d])
    );
  end

  assign tx_early_go = early_go[0];
  assign rx_irq      = rx_early_stat & rx_ie;

  p_go_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_early_go |-> $past(dir_en[0]));
  p_go_needs_thr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_early_go |-> $past(dir_thr[0]) != '0);
endmodule

// File: tb/tb_early_thresh_mon.sv
module tb_early_thresh_mon;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic tx_pkt_start = 0, tx_pkt_end = 0, rx_pkt_start = 0, rx_pkt_end = 0;
  logic [7:0] tx_bytes = 0, rx_bytes = 0;
  logic tx_early_go, rx_early_stat, rx_irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  early_thresh_mon dut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .tx_pkt_start, .tx_bytes, .tx_pkt_end, .rx_pkt_start, .rx_bytes, .rx_pkt_end,
    .tx_early_go, .rx_early_stat, .rx_irq
  );

  // behavioural reference: index 0 transmit, 1 receive
  int m_cnt[2];
  bit m_act[2], m_fired[2], m_go[2], m_en[2];
  int m_thr[2];
  bit m_stat, m_ie;
  bit [1:0] m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        m_cnt[d] = 0; m_act[d] = 0; m_fired[d] = 0; m_go[d] = 0; m_en[d] = 0; m_thr[d] = 0;
      end
      m_stat = 0; m_ie = 0; m_err = 0;
    end else begin
      bit st[2], en_[2], f[2];
      int by[2];
      st[0] = tx_pkt_start; st[1] = rx_pkt_start;
      en_[0] = tx_pkt_end;  en_[1] = rx_pkt_end;
      by[0] = tx_bytes;     by[1] = rx_bytes;
      for (int d = 0; d < 2; d++) begin
        bit open;
        int total;
        open = st[d] || m_act[d];
        total = (st[d] ? 0 : m_cnt[d]) + by[d];
        if (total > 65535) total = 65535;
        f[d] = open && m_en[d] && m_thr[d] != 0 && !(m_fired[d] && !st[d]) && total > m_thr[d] * 64;
        if (open) m_cnt[d] = total;
        m_act[d] = open && !en_[d];
        m_fired[d] = st[d] ? f[d] : (m_fired[d] || f[d]);
        m_go[d] = f[d];
        if (m_en[d] && m_thr[d] == 0) m_err[d] = 1;
        else if (reg_we && reg_addr == 2 && reg_wdata[2+d]) m_err[d] = 0;
      end
      if (f[1]) m_stat = 1;
      else if (reg_we && reg_addr == 2 && reg_wdata[0]) m_stat = 0;
      if (reg_we && reg_addr == 2) m_ie = reg_wdata[1];
      if (reg_we && reg_addr < 2) begin
        m_en[reg_addr] = reg_wdata[7];
        m_thr[reg_addr] = reg_wdata & 5'h1F;
      end
    end
  end

  function automatic int exp_rdata(int a);
    case (a)
      0, 1: return (m_en[a] << 7) | m_thr[a];
      2: return m_stat | (m_ie << 1) | (m_err[0] << 2) | (m_err[1] << 3);
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R3 tx_early_go model", tx_early_go, m_go[0]);
    check("R7 rx_early_stat model", rx_early_stat, m_stat);
    check("R8 rx_irq model", rx_irq, m_stat & m_ie);
    check("R2 reg_rdata model", reg_rdata, exp_rdata(reg_addr));
  endtask

  // inputs are held over exactly one rising edge, outputs are seen at the falling edge after it
  task automatic tick(bit ts, int tb, bit te, bit rs, int rb, bit re, bit we, int a, int wd);
    tx_pkt_start = ts; tx_bytes = tb[7:0]; tx_pkt_end = te;
    rx_pkt_start = rs; rx_bytes = rb[7:0]; rx_pkt_end = re;
    reg_we = we; reg_addr = a[1:0]; reg_wdata = wd[15:0];
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(int a, int wd); tick(0, 0, 0, 0, 0, 0, 1, a, wd); endtask
  task automatic rd(int a);         tick(0, 0, 0, 0, 0, 0, 0, a, 0);  endtask
  task automatic txb(bit s, int b, bit e); tick(s, b, e, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1 tx_early_go after reset", tx_early_go, 0);
    check("R1 rx_early_stat after reset", rx_early_stat, 0);
    check("R1 rx_irq after reset", rx_irq, 0);
    for (int a = 0; a < 3; a++) begin
      rd(a);
      check("R1 register after reset", reg_rdata, 0);
    end

    // R2 reserved bits
    wr(0, 16'hFFFF); rd(0);
    check("R2 tx control reserved bits", reg_rdata, 16'h009F);
    rd(3);
    check("R2 unused address", reg_rdata, 0);
    wr(0, 16'h0082);                       // enable, level 128

    // R3 exact level does not fire, one byte over does
    txb(1, 64, 0); check("R3 below level", tx_early_go, 0);
    txb(0, 64, 0); check("R3 equal level", tx_early_go, 0);
    txb(0, 1, 0);  check("R3 above level", tx_early_go, 1);
    txb(0, 200, 0); check("R4 no second pulse", tx_early_go, 0);
    txb(0, 0, 1);
    // R5 idle bytes ignored
    txb(0, 200, 0); check("R5 idle bytes", tx_early_go, 0);
    txb(1, 0, 0);
    txb(0, 128, 0); check("R5 fresh count at level", tx_early_go, 0);
    txb(0, 1, 0);   check("R5 fresh count above", tx_early_go, 1);
    // R4 start marker re-arms, start-cycle bytes count
    txb(1, 255, 0); check("R4 rearm at start", tx_early_go, 1);
    txb(1, 255, 0); check("R4 back to back start", tx_early_go, 1);
    txb(0, 0, 1);   check("R4 after pulse", tx_early_go, 0);

    // R6 disabled
    wr(0, 16'h0002);
    txb(1, 255, 0); check("R6 disabled start", tx_early_go, 0);
    txb(0, 255, 1); check("R6 disabled burst", tx_early_go, 0);

    // R7 R8 receive side
    wr(1, 16'h0081);                       // level 64
    tick(0, 0, 0, 1, 65, 0, 0, 2, 0);
    check("R7 status set", rx_early_stat, 1);
    check("R8 irq masked", rx_irq, 0);
    wr(2, 16'h0002);
    check("R8 irq enabled", rx_irq, 1);
    wr(2, 16'h0003);
    check("R7 status cleared", rx_early_stat, 0);
    check("R8 irq follows status", rx_irq, 0);
    rd(2);
    check("R7 event readback", reg_rdata, 16'h0002);
    tick(0, 0, 0, 0, 0, 1, 0, 0, 0);
    tick(0, 0, 0, 1, 100, 0, 1, 2, 16'h0003);
    check("R7 set wins over clear", rx_early_stat, 1);
    check("R8 irq with set", rx_irq, 1);
    tick(0, 0, 0, 0, 0, 1, 0, 0, 0);

    // R9 zero threshold with enable
    wr(0, 16'h0080);
    tick(1, 255, 0, 0, 0, 0, 0, 2, 0);
    check("R9 no trigger at zero threshold", tx_early_go, 0);
    check("R9 tx config error set", (reg_rdata >> 2) & 1, 1);
    txb(0, 255, 1);
    check("R9 no trigger later", tx_early_go, 0);
    wr(0, 16'h0000);
    wr(2, 16'h0006);
    rd(2);
    check("R9 config error cleared", (reg_rdata >> 2) & 1, 0);
    check("R9 rx config error untouched", (reg_rdata >> 3) & 1, 0);

    repeat (4) rd(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule